// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Carry and Borrow Flags

This block is the execute stage of a small accumulator machine. It holds the accumulator and two one-bit status registers: a carry flag and a borrow flag. On each clock edge where the commit input is high, it combines the accumulator with a memory operand under a 4-bit operation code and writes back the result. The supported operations are an equality test, a nonzero test, addition, subtraction and a direct load. The equality and nonzero tests each produce 0 or 1. Addition and subtraction are modular, and their carry-out and borrow-out go into two separate flag registers.

The surrounding machine fetches instructions and operands, handles I/O and performs program-counter arithmetic. It feeds the opcode and operand to this block and asserts the commit input once per executed instruction. The accumulator-is-zero output is driven straight from the accumulator register so that conditional branch logic can use it in the same cycle.

Top module: `acc_alu`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator, the carry flag and the borrow flag to 0. Reset takes priority over `commit`.
- R2: With `commit` high and opcode 4'b0001, the accumulator becomes 1 if it equalled the operand and 0 otherwise.
- R3: With `commit` high and opcode 4'b0010, the accumulator becomes 1 if either the accumulator or the operand was nonzero, and 0 if both were zero.
- R4: With `commit` high and opcode 4'b0011, the accumulator becomes (accumulator + operand) mod 2^W, and the carry flag becomes the carry out of bit W-1. A sum with no carry clears the carry flag.
- R5: With `commit` high and opcode 4'b0100, the accumulator becomes (accumulator − operand) mod 2^W, and the borrow flag becomes 1 exactly when the operand exceeded the accumulator. A subtraction with no borrow clears the borrow flag.
- R6: With `commit` high and opcode 4'b0101, the accumulator becomes the operand.
- R7: With `commit` high and any other opcode (4'b0000 or 4'b0110 through 4'b1111), the accumulator and both flags keep their values.
- R8: With `commit` low, the accumulator and both flags keep their values whatever the opcode and operand are.
- R9: `acc_zero` is high exactly when the accumulator register holds 0, with no added delay.
- R10: The carry flag changes only on addition and the borrow flag changes only on subtraction. Every other operation leaves each flag untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| commit | input | 1 | Write back the result of the current opcode at this edge |
| opcode | input | 4 | Operation code |
| operand | input | W (4) | Memory operand |
| acc_q | output | W (4) | Accumulator register |
| carry_q | output | 1 | Carry flag register |
| borrow_q | output | 1 | Borrow flag register |
| acc_zero | output | 1 | High when the accumulator is 0 |

## Verification
The accumulator and both flags are each a single register stage, so the result of a stimulus applied before a rising edge is due right after that edge. `acc_zero` follows the accumulator with no further delay. The bench changes the inputs on falling edges, advances its reference model at the rising edge those inputs meet, and compares all four outputs at the next falling edge. Every comparison therefore lands exactly one edge after its stimulus. Random commit, opcode, operand and occasional reset values are mixed with directed cases that hit carry and borrow wrap-around, zero-operand tests and opcodes outside the defined set.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_EQ   = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_NZ   = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_ADD  = 4'b0011;
    localparam logic [OPC_W-1:0] OPC_SUB  = 4'b0100;
    localparam logic [OPC_W-1:0] OPC_LOAD = 4'b0101;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EQ,
        SEL_NZ,
        SEL_ADD,
        SEL_SUB,
        SEL_LOAD
    } res_sel_e;

    typedef struct packed {
        res_sel_e sel;
        logic     wr_acc;
        logic     wr_carry;
        logic     wr_borrow;
    } alu_ctl_t;

    function automatic alu_ctl_t decode_op(logic [OPC_W-1:0] opc);
        alu_ctl_t c;
        c.sel       = SEL_NONE;
        c.wr_acc    = 1'b0;
        c.wr_carry  = 1'b0;
        c.wr_borrow = 1'b0;
        case (opc)
            OPC_EQ:   begin c.sel = SEL_EQ;   c.wr_acc = 1'b1; end
            OPC_NZ:   begin c.sel = SEL_NZ;   c.wr_acc = 1'b1; end
            OPC_ADD:  begin c.sel = SEL_ADD;  c.wr_acc = 1'b1; c.wr_carry  = 1'b1; end
            OPC_SUB:  begin c.sel = SEL_SUB;  c.wr_acc = 1'b1; c.wr_borrow = 1'b1; end
            OPC_LOAD: begin c.sel = SEL_LOAD; c.wr_acc = 1'b1; end
            default:  c.sel = SEL_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0]   chain;
    logic [W-1:0] b_eff;

    assign chain[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign b_eff[i]    = b[i] ^ sub;
        assign sum[i]      = a[i] ^ b_eff[i] ^ chain[i];
        assign chain[i+1]  = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
    end

    assign cout = chain[W];
endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
    import acc_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] operand,
    input  res_sel_e     sel,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         borrow_out
);
    logic [W-1:0] as_sum;
    logic         as_cout;
    logic         do_sub;

    assign do_sub = (sel == SEL_SUB);

    acc_alu_addsub #(.W(W)) u_addsub (
        .a    (acc),
        .b    (operand),
        .sub  (do_sub),
        .sum  (as_sum),
        .cout (as_cout)
    );

    assign carry_out  = as_cout;
    assign borrow_out = ~as_cout;

    always_comb begin
        case (sel)
            SEL_EQ:   result = W'(acc == operand);
            SEL_NZ:   result = W'((|acc) | (|operand));
            SEL_ADD,
            SEL_SUB:  result = as_sum;
            SEL_LOAD: result = operand;
            default:  result = acc;
        endcase
    end
endmodule

// File: rtl/acc_alu_regs.sv
module acc_alu_regs
    import acc_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         commit,
    input  alu_ctl_t     ctl,
    input  logic [W-1:0] next_acc,
    input  logic         next_carry,
    input  logic         next_borrow,
    output logic [W-1:0] acc,
    output logic         carry,
    output logic         borrow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            carry  <= 1'b0;
            borrow <= 1'b0;
        end else if (commit) begin
            if (ctl.wr_acc)    acc    <= next_acc;
            if (ctl.wr_carry)  carry  <= next_carry;
            if (ctl.wr_borrow) borrow <= next_borrow;
        end
    end
endmodule

// File: rtl/acc_alu_zero.sv
module acc_alu_zero #(
    parameter int W = 4
) (
    input  logic [W-1:0] value,
    output logic         is_zero
);
    logic [W:0] none_set;

    assign none_set[0] = 1'b1;
    for (genvar i = 0; i < W; i++) begin : g_scan
        assign none_set[i+1] = none_set[i] & ~value[i];
    end

    assign is_zero = none_set[W];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         commit,
    input  logic [3:0]   opcode,
    input  logic [W-1:0] operand,
    output logic [W-1:0] acc_q,
    output logic         carry_q,
    output logic         borrow_q,
    output logic         acc_zero
);
    alu_ctl_t     ctl;
    logic [W-1:0] dp_result;
    logic         dp_carry;
    logic         dp_borrow;

    always_comb ctl = decode_op(opcode);

    acc_alu_datapath #(.W(W)) u_dp (
        .acc        (acc_q),
        .operand    (operand),
        .sel        (ctl.sel),
        .result     (dp_result),
        .carry_out  (dp_carry),
        .borrow_out (dp_borrow)
    );

    acc_alu_regs #(.W(W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .ctl         (ctl),
        .next_acc    (dp_result),
        .next_carry  (dp_carry),
        .next_borrow (dp_borrow),
        .acc         (acc_q),
        .carry       (carry_q),
        .borrow      (borrow_q)
    );

    acc_alu_zero #(.W(W)) u_zero (
        .value   (acc_q),
        .is_zero (acc_zero)
    );
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
    import acc_alu_pkg::*;
#(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         commit,
    input logic [3:0]   opcode,
    input logic [W-1:0] operand,
    input logic [W-1:0] acc_q,
    input logic         carry_q,
    input logic         borrow_q,
    input logic         acc_zero
);
    logic rst_seen;

    always_ff @(posedge clk) rst_seen <= rst;

    always @(posedge clk) begin
        if (rst_seen === 1'b1)
            AST_RESET_CLEAR: assert (acc_q == '0 && !carry_q && !borrow_q); // R1
    end

    AST_EQ_RESULT: assert property (@(posedge clk) disable iff (rst)
        commit && opcode == OPC_EQ |=> acc_q == W'($past(acc_q) == $past(operand))); // R2

    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
        commit && opcode == OPC_ADD
        |=> carry_q == (({1'b0, $past(acc_q)} + {1'b0, $past(operand)}) > (W+1)'((1 << W) - 1))); // R4

    AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
        commit && opcode == OPC_SUB |=> borrow_q == ($past(operand) > $past(acc_q))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(acc_q) && $stable(carry_q) && $stable(borrow_q)); // R8

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        acc_zero == (acc_q == '0)); // R9

    AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (rst)
        commit && opcode != OPC_ADD |=> $stable(carry_q)); // R10

    AST_BORROW_KEEP: assert property (@(posedge clk) disable iff (rst)
        commit && opcode != OPC_SUB |=> $stable(borrow_q)); // R10
endmodule

bind acc_alu acc_alu_checker #(.W(W)) u_chk (.*);

// File: tb/acc_alu_test.sv
module acc_alu_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         commit = 1'b0;
    logic [3:0]   opcode = '0;
    logic [W-1:0] operand = '0;
    logic [W-1:0] acc_q;
    logic         carry_q, borrow_q, acc_zero;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [W-1:0] m_acc;
    logic         m_c, m_b;

    always #2.5 clk = ~clk;

    acc_alu #(.W(W)) uut (
        .clk(clk), .rst(rst), .commit(commit), .opcode(opcode), .operand(operand),
        .acc_q(acc_q), .carry_q(carry_q), .borrow_q(borrow_q), .acc_zero(acc_zero)
    );

    task automatic check(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    function automatic string acc_req(logic r, logic en, logic [3:0] op);
        if (r) return "R1";
        if (!en) return "R8";
        case (op)
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0011: return "R4";
            4'b0100: return "R5";
            4'b0101: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [W:0] exp_add(logic [W-1:0] a, logic [W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic model_step(logic r, logic en, logic [3:0] op, logic [W-1:0] d);
        logic [W:0] s;
        if (r) begin
            m_acc = '0; m_c = 1'b0; m_b = 1'b0;
        end else if (en) begin
            case (op)
                4'b0001: m_acc = (m_acc == d) ? W'(1) : W'(0);
                4'b0010: m_acc = (m_acc != 0 || d != 0) ? W'(1) : W'(0);
                4'b0011: begin s = exp_add(m_acc, d); m_acc = s[W-1:0]; m_c = s[W]; end
                4'b0100: begin m_b = (d > m_acc); m_acc = m_acc - d; end
                4'b0101: m_acc = d;
                default: ;
            endcase
        end
    endtask

    task automatic compare(string req, string cflag, string bflag);
        check(req, "acc", int'(acc_q), int'(m_acc));
        check(cflag, "carry", int'(carry_q), int'(m_c));
        check(bflag, "borrow", int'(borrow_q), int'(m_b));
        check("R9", "acc_zero", int'(acc_zero), int'(m_acc == 0));
    endtask

    // Inputs change on a falling edge; results are due after the next rising edge.
    task automatic step(logic r, logic en, logic [3:0] op, logic [W-1:0] d);
        string rq, cq, bq;
        rst = r; commit = en; opcode = op; operand = d;
        rq = acc_req(r, en, op);
        cq = r ? "R1" : (en && op == 4'b0011) ? "R4" : "R10";
        bq = r ? "R1" : (en && op == 4'b0100) ? "R5" : "R10";
        @(posedge clk);
        model_step(r, en, op, d);
        @(negedge clk);
        compare(rq, cq, bq);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        m_acc = '0; m_c = 1'b0; m_b = 1'b0;
        @(negedge clk);
        step(1'b1, 1'b0, 4'b0000, 4'd0);            // R1 reset state
        // R6 load, R4 carry wrap 15+1
        step(1'b0, 1'b1, 4'b0101, 4'd15);
        step(1'b0, 1'b1, 4'b0011, 4'd1);            // R4 -> 0, carry 1
        step(1'b0, 1'b1, 4'b0011, 4'd3);            // R4 carry cleared
        // R5 borrow 3-4, then no-borrow clears
        step(1'b0, 1'b1, 4'b0100, 4'd4);
        step(1'b0, 1'b1, 4'b0100, 4'd15);           // 15-15 = 0, borrow 0
        // R3 both zero, then nonzero operand
        step(1'b0, 1'b1, 4'b0010, 4'd0);
        step(1'b0, 1'b1, 4'b0010, 4'd9);
        // R2 equal and not equal
        step(1'b0, 1'b1, 4'b0001, 4'd1);
        step(1'b0, 1'b1, 4'b0001, 4'd7);
        // R8 commit low with an active opcode
        step(1'b0, 1'b1, 4'b0101, 4'd10);
        step(1'b0, 1'b0, 4'b0101, 4'd3);
        step(1'b0, 1'b0, 4'b0011, 4'd15);
        // R7 every undefined opcode
        step(1'b0, 1'b1, 4'b0000, 4'd5);
        for (int k = 6; k < 16; k++) step(1'b0, 1'b1, 4'(k), 4'(k));
        // R1 reset beats commit
        step(1'b0, 1'b1, 4'b0011, 4'd15);
        step(1'b1, 1'b1, 4'b0101, 4'd9);
        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic r, en;
            logic [3:0] op;
            r  = ($urandom % 64) == 0;
            en = ($urandom % 8) != 0;
            op = (($urandom % 4) == 0) ? 4'($urandom) : 4'(1 + $urandom % 5);
            step(r, en, op, W'($urandom));
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule